// File: doc/BRIEF.md
# Software Flow Control Character Watcher

This block gives one serial channel its in-band flow control. It watches every character the receiver delivers and compares it with a programmed stop pattern and a programmed go pattern. Each pattern is one byte, or two bytes that must arrive back to back, and one mode input selects which length applies. When the stop pattern is seen, the block raises a flag and, if enabled, an interrupt. It also holds off the transmitter, but never in the middle of a character: a character that is already being sent is allowed to finish.

While the channel is held off, the go pattern clears the flag and releases the transmitter. In the relaxed resume mode, any received character releases it, although a stop pattern is still recognised as a stop. Received characters are never consumed here. They keep flowing to the receive buffer, and a separate block decides whether to filter them.

Top module: `swFlowCtl`

## Requirements
- R1: After reset `txHold`, `xoffFlag` and `xoffIrq` are all 0.
- R2: With `pairMode`=0, a received character equal to `xoffFirst` is a stop match. If `txBusy` is 0 in that cycle, `txHold` and `xoffFlag` are 1 from the next clock edge.
- R3: With `pairMode`=1, a stop match needs two consecutive received characters (consecutive `rxValid` beats, with idle cycles between them allowed): `xoffFirst`, then `xoffSecond`. The same rule, using `xonFirst` and `xonSecond`, applies to the go pattern.
- R4: In pair mode, a first character that is not followed by the matching second character is discarded. The character that broke the pair is then itself tested as a new first character.
- R5: A stop match while `txBusy`=1 sets `xoffFlag` but leaves `txHold` at 0 until the edge on which `txCharDone` is 1. `txHold` is 1 from that edge on.
- R6: A go match while a halt is pending cancels it. `txHold` stays 0 and `xoffFlag` clears.
- R7: A go match while `txHold`=1 clears both `txHold` and `xoffFlag` on the next edge.
- R8: `xoffIrq` is 1 exactly when `xoffFlag`=1 and `xoffIrqEn`=1.
- R9: With `anyXonMode`=1, any received character that is not a stop match acts as a go match while the channel is held or a halt is pending.
- R10: A go match while running has no effect. A stop match while already held keeps `txHold` and `xoffFlag` at 1.
- R11: If a stop match and `txCharDone` fall in the same cycle while `txBusy`=1, `txHold` is 1 from the next edge.
- R12: If a character matches both the stop and the go pattern, the stop match wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received character strobe |
| rxData | input | DATA_W | Received character |
| xoffFirst | input | DATA_W | Stop pattern, first (or only) byte |
| xoffSecond | input | DATA_W | Stop pattern, second byte |
| xonFirst | input | DATA_W | Go pattern, first (or only) byte |
| xonSecond | input | DATA_W | Go pattern, second byte |
| pairMode | input | 1 | 1 = two-byte patterns, 0 = one-byte patterns |
| anyXonMode | input | 1 | 1 = any received character resumes |
| txBusy | input | 1 | Transmitter is shifting a character |
| txCharDone | input | 1 | Transmitter finished a character this cycle |
| xoffIrqEn | input | 1 | Interrupt enable for the stop flag |
| txHold | output | 1 | Transmitter must not start a new character |
| xoffFlag | output | 1 | Stop pattern seen and not yet cleared |
| xoffIrq | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: a flow pattern arriving, and the transmitter's character-complete strobe. The bench provokes this in two ways. It places a stop character in the same cycle as `txCharDone` while busy (R11). It also places a go character in the same cycle as `txCharDone` while a halt is pending, where the cancel must win and `txHold` must stay 0. A long random phase then mixes pattern bytes, busy and done strobes and mode changes, so that these collisions recur. A behavioural model in the bench judges `txHold`, `xoffFlag` and `xoffIrq` after every clock edge.

// File: rtl/swFlowPkg.sv
package swFlowPkg;
  typedef enum logic [1:0] {
    FC_RUN  = 2'd0,
    FC_PEND = 2'd1,
    FC_HOLD = 2'd2
  } flowState_t;

  // strobes from the matching datapath to the control
  typedef struct packed {
    logic rxStrobe;
    logic xoffHit;
    logic xonHit;
  } flowEvt_t;
endpackage

// File: rtl/swFlowPattern.sv
module swFlowPattern #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] patFirst,
  input  logic [DATA_W-1:0] patSecond,
  input  logic              pairMode,
  output logic              hit
);
  logic firstSeen;
  logic isFirst;

  assign isFirst = (rxData == patFirst);

  always_comb begin
    if (!rxValid) hit = 1'b0;
    else if (pairMode) hit = firstSeen && (rxData == patSecond);
    else hit = isFirst;
  end

  // a broken pair is dropped; the breaking byte is retested as a first byte
  always_ff @(posedge clk) begin
    if (!rstN) firstSeen <= 1'b0;
    else if (rxValid) firstSeen <= pairMode && isFirst && !hit;
  end

  AST_PAIR_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rstN)
    (pairMode && hit) |-> (firstSeen && rxValid)) else $error("pair hit without first byte"); // R3
endmodule

// File: rtl/swFlowDatapath.sv
module swFlowDatapath
  import swFlowPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] xoffFirst,
  input  logic [DATA_W-1:0] xoffSecond,
  input  logic [DATA_W-1:0] xonFirst,
  input  logic [DATA_W-1:0] xonSecond,
  input  logic              pairMode,
  output flowEvt_t          evt
);
  localparam int N_PAT = 2;  // index 0: stop pattern, 1: go pattern

  logic [DATA_W-1:0] firstTab  [N_PAT];
  logic [DATA_W-1:0] secondTab [N_PAT];
  logic [N_PAT-1:0]  hits;

  assign firstTab[0]  = xoffFirst;
  assign firstTab[1]  = xonFirst;
  assign secondTab[0] = xoffSecond;
  assign secondTab[1] = xonSecond;

  for (genvar i = 0; i < N_PAT; i++) begin : gPat
    swFlowPattern #(.DATA_W(DATA_W)) uPat (
      .clk      (clk),
      .rstN     (rstN),
      .rxValid  (rxValid),
      .rxData   (rxData),
      .patFirst (firstTab[i]),
      .patSecond(secondTab[i]),
      .pairMode (pairMode),
      .hit      (hits[i])
    );
  end

  assign evt.rxStrobe = rxValid;
  assign evt.xoffHit  = hits[0];
  assign evt.xonHit   = hits[1];
endmodule

// File: rtl/swFlowCtrl.sv
module swFlowCtrl
  import swFlowPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flowEvt_t evt,
  input  logic     anyXonMode,
  input  logic     txBusy,
  input  logic     txCharDone,
  input  logic     xoffIrqEn,
  output logic     txHold,
  output logic     xoffFlag,
  output logic     xoffIrq
);
  flowState_t state, stateNext;
  logic resume;

  // stop match outranks any go interpretation of the same byte
  assign resume = evt.rxStrobe && !evt.xoffHit && (evt.xonHit || anyXonMode);

  always_comb begin
    stateNext = state;
    unique case (state)
      FC_RUN:  if (evt.xoffHit) stateNext = (txBusy && !txCharDone) ? FC_PEND : FC_HOLD;
      FC_PEND: begin
        if (resume) stateNext = FC_RUN;
        else if (txCharDone) stateNext = FC_HOLD;
      end
      FC_HOLD: if (resume) stateNext = FC_RUN;
      default: stateNext = FC_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= FC_RUN;
      xoffFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (evt.xoffHit) xoffFlag <= 1'b1;
      else if (resume && state != FC_RUN) xoffFlag <= 1'b0;
    end
  end

  assign txHold  = (state == FC_HOLD);
  assign xoffIrq = xoffFlag && xoffIrqEn;

  AST_HOLD_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    txHold |-> xoffFlag) else $error("hold without flag"); // R7
  AST_STOP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evt.xoffHit |=> xoffFlag) else $error("stop match lost"); // R2
  AST_DONE_COMMITS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (state == FC_PEND && txCharDone && !resume) |=> txHold) else $error("pending halt not taken"); // R5
  AST_GO_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (txHold && evt.xonHit && !evt.xoffHit) |=> (!txHold && !xoffFlag)) else $error("go match ignored"); // R7
  AST_BUSY_DEFERS: assert property (@(posedge clk) disable iff (!rstN)
    (!txHold && evt.xoffHit && txBusy && !txCharDone) |=> !txHold) else $error("halt cut a character"); // R5
endmodule

// File: rtl/swFlowCtl.sv
module swFlowCtl
  import swFlowPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] xoffFirst,
  input  logic [DATA_W-1:0] xoffSecond,
  input  logic [DATA_W-1:0] xonFirst,
  input  logic [DATA_W-1:0] xonSecond,
  input  logic              pairMode,
  input  logic              anyXonMode,
  input  logic              txBusy,
  input  logic              txCharDone,
  input  logic              xoffIrqEn,
  output logic              txHold,
  output logic              xoffFlag,
  output logic              xoffIrq
);
  flowEvt_t evt;

  swFlowDatapath #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .xoffFirst (xoffFirst),
    .xoffSecond(xoffSecond),
    .xonFirst  (xonFirst),
    .xonSecond (xonSecond),
    .pairMode  (pairMode),
    .evt       (evt)
  );

  swFlowCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .anyXonMode(anyXonMode),
    .txBusy    (txBusy),
    .txCharDone(txCharDone),
    .xoffIrqEn (xoffIrqEn),
    .txHold    (txHold),
    .xoffFlag  (xoffFlag),
    .xoffIrq   (xoffIrq)
  );
endmodule

// File: tb/swFlowCtl_test.sv
module swFlowCtl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic [7:0] xoffFirst = 8'h13, xoffSecond = 8'h93;
  logic [7:0] xonFirst = 8'h11, xonSecond = 8'h91;
  logic       pairMode = 1'b0, anyXonMode = 1'b0;
  logic       txBusy = 1'b0, txCharDone = 1'b0, xoffIrqEn = 1'b1;
  logic       txHold, xoffFlag, xoffIrq;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state: 0 run, 1 pending, 2 held
  int mState = 0;
  bit mFlag = 0, mOffPart = 0, mOnPart = 0;

  always #5 clk = ~clk;

  swFlowCtl uut (.*);

  always @(posedge clk) begin
    bit offHit, onHit, goNow;
    if (!rstN) begin
      mState = 0; mFlag = 0; mOffPart = 0; mOnPart = 0;
    end else begin
      offHit = rxValid && (pairMode ? (mOffPart && rxData == xoffSecond) : rxData == xoffFirst);
      onHit  = rxValid && (pairMode ? (mOnPart && rxData == xonSecond) : rxData == xonFirst);
      if (rxValid) begin
        mOffPart = pairMode && rxData == xoffFirst && !offHit;
        mOnPart  = pairMode && rxData == xonFirst && !onHit;
      end
      goNow = rxValid && !offHit && (onHit || anyXonMode);
      if (offHit) begin
        mFlag = 1;
        if (mState == 0) mState = (txBusy && !txCharDone) ? 1 : 2;
        else if (mState == 1 && txCharDone) mState = 2;
      end else if (goNow && mState != 0) begin
        mFlag = 0; mState = 0;
      end else if (mState == 1 && txCharDone) begin
        mState = 2;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      bit eHold, eIrq;
      eHold = (mState == 2);
      eIrq = mFlag && xoffIrqEn;
      vectors++;
      if (txHold !== eHold || xoffFlag !== mFlag || xoffIrq !== eIrq) begin
        miscompares++;
        $display("FAIL %s: hold/flag/irq = %b%b%b expected %b%b%b at %0t",
                 curReq, txHold, xoffFlag, xoffIrq, eHold, mFlag, eIrq, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 0; txCharDone = 0;
    end
  endtask

  task automatic sendChar(logic [7:0] c, bit doneToo = 0);
    @(negedge clk);
    rxValid = 1; rxData = c; txCharDone = doneToo;
    @(negedge clk);
    rxValid = 0; txCharDone = 0;
  endtask

  task automatic strobeDone();
    @(negedge clk);
    txCharDone = 1;
    @(negedge clk);
    txCharDone = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    // R1 explicit reset check
    vectors++;
    if (txHold !== 0 || xoffFlag !== 0 || xoffIrq !== 0) begin
      miscompares++;
      $display("FAIL R1: %b%b%b expected 000", txHold, xoffFlag, xoffIrq);
    end

    curReq = "R2"; sendChar(8'h41); sendChar(xoffFirst); idle(2);
    curReq = "R8"; xoffIrqEn = 0; idle(2); xoffIrqEn = 1; idle(1);
    curReq = "R10"; sendChar(xoffFirst); idle(1);
    curReq = "R7"; sendChar(xonFirst); idle(2);
    curReq = "R10"; sendChar(xonFirst); idle(1);

    curReq = "R3"; pairMode = 1;
    sendChar(xoffFirst); idle(3); sendChar(xoffSecond); idle(2);
    sendChar(xonFirst); sendChar(xonSecond); idle(2);
    curReq = "R4";
    sendChar(xoffFirst); sendChar(8'h55); sendChar(xoffSecond); idle(1);
    sendChar(xoffFirst); sendChar(xoffFirst); sendChar(xoffSecond); idle(1);
    sendChar(xonFirst); sendChar(xonFirst); sendChar(xonSecond); idle(1);
    pairMode = 0;

    curReq = "R5"; txBusy = 1;
    sendChar(xoffFirst); idle(3); strobeDone(); idle(2);
    sendChar(xonFirst); idle(1);
    curReq = "R6";
    sendChar(xoffFirst); idle(1); sendChar(xonFirst); idle(1); strobeDone(); idle(1);
    sendChar(xoffFirst); sendChar(xonFirst, 1); idle(2);
    curReq = "R11";
    sendChar(xoffFirst, 1); idle(2); sendChar(xonFirst); txBusy = 0; idle(1);

    curReq = "R9"; anyXonMode = 1;
    sendChar(xoffFirst); idle(1); sendChar(8'h7E); idle(2);
    sendChar(xoffFirst); sendChar(xoffFirst); idle(1); sendChar(8'h20); idle(1);
    anyXonMode = 0;

    curReq = "R12"; xonFirst = 8'h13;
    sendChar(8'h13); idle(2); xonFirst = 8'h11; sendChar(xonFirst); idle(1);

    curReq = "R3";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 199) == 0) pairMode = ~pairMode;
      if ($urandom_range(0, 149) == 0) anyXonMode = ~anyXonMode;
      if ($urandom_range(0, 49) == 0) xoffIrqEn = ~xoffIrqEn;
      txBusy = $urandom_range(0, 2) != 0;
      txCharDone = txBusy && ($urandom_range(0, 3) == 0);
      rxValid = $urandom_range(0, 2) == 0;
      case ($urandom_range(0, 7))
        0: rxData = xoffFirst;
        1: rxData = xoffSecond;
        2: rxData = xonFirst;
        3: rxData = xonSecond;
        default: rxData = 8'($urandom);
      endcase
    end
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule